// File: doc/BRIEF.md
# Two-Stage Virtual Channel Allocator

This block hands out output virtual channels to head flits that wait in the input virtual channels of a router with P ports and V channels per port. Each of the P×V input channels presents a valid flag, the output port chosen by the routing stage, and a mask of the channels at that port the flit may use. The allocator keeps one busy bit per output channel.

The allocation runs in two stages within one cycle. In the first stage, each input channel picks one free, permitted channel at its target port, so it makes exactly one request. In the second stage, each output channel has a round-robin arbiter with P×V request inputs, because an input channel of any port may target it. A winner sees its grant flag and the granted channel index in the same cycle. That output channel is busy from the next cycle until a release pulse reports that its tail flit has left.

Top module: `vca_alloc`

## Requirements
- R1: After reset every output channel is free, no grant is raised, and every round-robin pointer is at input index 0.
- R2: A grant goes only to an input channel whose valid flag is high. The reported index (0..V-1, flattened output channel = port×V + index) names a channel that is set in that input's mask and free at its requested port.
- R3: In one cycle, no output channel is granted to more than one input channel.
- R4: An input channel whose permitted channels at its target port are all busy receives no grant.
- R5: In the default policy, stage one picks the lowest-index free permitted channel. Among input channels contending for one output channel, the winner is the first requester at or after that channel's pointer, wrapping at P×V. After a grant the pointer moves to winner+1, and without a grant it stays.
- R6: A granted output channel reads busy from the next cycle. It stays busy until a release pulse, which clears it at the following edge. It cannot be granted in the cycle of the pulse, only in the cycle after.
- R7: A release pulse on an output channel that is already free has no effect on any busy bit.
- R8: An input channel that loses stage two and keeps its valid flag high is considered again in the next cycle against the updated busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | P*V | Head flit waiting, one bit per input channel |
| in_port | input | P*V*clog2(P) | Requested output port per input channel |
| in_vcmask | input | P*V*V | Permitted channels at the requested port per input channel |
| ovc_release | input | P*V | Tail departed, one pulse bit per output channel |
| out_grant | output | P*V | Grant this cycle, one bit per input channel |
| out_grant_vc | output | P*V*clog2(V) | Granted channel index at the port, zero when no grant |
| ovc_busy | output | P*V | Output channel allocated |

## Verification
The assertions assume that every requested port is below P. They also assume that a granted input channel lowers its valid flag after the grant edge, and that release pulses come only from owners or as deliberate no-ops on free channels. The stimulus keeps these rules. Requests are drawn from the legal port range, and a head is turned into a holder once the bench model sees its grant. Every release comes either from a holder that ends its hold or from a random pulse on a channel the model knows is free. Losers keep their requests unchanged, so retry and pointer rotation are exercised under real contention.

// File: rtl/vca_pkg.sv
package vca_pkg;
   typedef enum logic {
      PICK_LOW  = 1'b0,
      PICK_HIGH = 1'b1
   } pick_e;
endpackage

// File: rtl/vca_pick.sv
module vca_pick
   import vca_pkg::*;
#(
   parameter int    V    = 4,
   parameter pick_e PICK = PICK_LOW,
   localparam int   VW   = $clog2(V)
) (
   input  logic [V-1:0]  avail,
   output logic          found,
   output logic [VW-1:0] idx
);
   generate
      if (PICK == PICK_LOW) begin : g_low
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int v = V - 1; v >= 0; v--) begin
               if (avail[v]) begin
                  found = 1'b1;
                  idx   = VW'(v);
               end
            end
         end
      end else begin : g_high
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int v = 0; v < V; v++) begin
               if (avail[v]) begin
                  found = 1'b1;
                  idx   = VW'(v);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/vca_rr_arb.sv
module vca_rr_arb #(
   parameter int  N  = 40,
   localparam int NW = $clog2(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   logic [NW-1:0] ptr_q;
   logic [NW-1:0] win;
   logic          hit;

   always_comb begin
      gnt = '0;
      hit = 1'b0;
      win = '0;
      for (int k = 0; k < N; k++) begin
         int pos;
         pos = int'(ptr_q) + k;
         if (pos >= N) pos = pos - N;
         if (!hit && req[pos]) begin
            hit      = 1'b1;
            gnt[pos] = 1'b1;
            win      = NW'(pos);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (hit) begin
         ptr_q <= (int'(win) == N - 1) ? '0 : win + NW'(1);
      end
   end

   assert_single_winner_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   assert_grant_to_requester_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
endmodule

// File: rtl/vca_busy.sv
module vca_busy #(
   parameter int N = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] busy
);
   always_ff @(posedge clk) begin
      if (!rst_n) busy <= '0;
      else        busy <= (busy & ~clr) | set;
   end

   generate
      for (genvar j = 0; j < N; j++) begin : g_chk
         assert_release_frees_R6 : assert property (@(posedge clk) disable iff (!rst_n)
            (clr[j] && !set[j]) |=> !busy[j]);
         assert_holds_until_release_R6 : assert property (@(posedge clk) disable iff (!rst_n)
            (busy[j] && !clr[j]) |=> busy[j]);
         assert_free_stays_free_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            (!busy[j] && !set[j]) |=> !busy[j]);
      end
   endgenerate
endmodule

// File: rtl/vca_alloc.sv
module vca_alloc
   import vca_pkg::*;
#(
   parameter int    P    = 10,
   parameter int    V    = 4,
   parameter pick_e PICK = PICK_LOW,
   localparam int   N    = P * V,
   localparam int   PW   = $clog2(P),
   localparam int   VW   = $clog2(V),
   localparam int   NW   = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    in_valid,
   input  logic [N*PW-1:0] in_port,
   input  logic [N*V-1:0]  in_vcmask,
   input  logic [N-1:0]    ovc_release,
   output logic [N-1:0]    out_grant,
   output logic [N*VW-1:0] out_grant_vc,
   output logic [N-1:0]    ovc_busy
);
   generate
      if (P < 2 || V < 2) begin : g_bad_size
         $error("vca_alloc needs at least two ports and two channels per port");
      end
   endgenerate

   logic [N-1:0]  s1_found;
   logic [N-1:0]  s1_req;
   logic [VW-1:0] s1_vc  [N];
   logic [NW-1:0] s1_tgt [N];
   logic [N-1:0]  s2_gnt [N];
   logic [N-1:0]  ovc_set;

   // stage one: one request per input channel
   generate
      for (genvar i = 0; i < N; i++) begin : g_in
         logic [PW-1:0] port;
         logic [V-1:0]  avail;
         logic          g;

         assign port = in_port[i*PW +: PW];

         always_comb begin
            avail = '0;
            for (int p = 0; p < P; p++) begin
               if (int'(port) == p) avail = in_vcmask[i*V +: V] & ~ovc_busy[p*V +: V];
            end
         end

         vca_pick #(.V(V), .PICK(PICK)) u_pick (
            .avail (avail),
            .found (s1_found[i]),
            .idx   (s1_vc[i])
         );

         assign s1_tgt[i] = NW'(int'(port) * V + int'(s1_vc[i]));
         assign s1_req[i] = in_valid[i] & s1_found[i];

         always_comb begin
            g = 1'b0;
            for (int j = 0; j < N; j++) g = g | s2_gnt[j][i];
         end
         assign out_grant[i] = g;
         assign out_grant_vc[i*VW +: VW] = g ? s1_vc[i] : '0;

         assert_grant_needs_valid_R2 : assert property (@(posedge clk) disable iff (!rst_n)
            out_grant[i] |-> in_valid[i]);
         assert_grant_in_mask_R2 : assert property (@(posedge clk) disable iff (!rst_n)
            out_grant[i] |-> in_vcmask[i*V + int'(out_grant_vc[i*VW +: VW])]);
         assert_grant_only_free_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            out_grant[i] |-> !ovc_busy[s1_tgt[i]]);
         assert_grant_marks_busy_R6 : assert property (@(posedge clk) disable iff (!rst_n)
            out_grant[i] |=> ovc_busy[$past(s1_tgt[i])]);
      end
   endgenerate

   // stage two: one P*V-input arbiter per output channel
   generate
      for (genvar j = 0; j < N; j++) begin : g_out
         logic [N-1:0] req_j;
         logic [N-1:0] took;

         always_comb begin
            for (int i = 0; i < N; i++) begin
               req_j[i] = s1_req[i] && (int'(s1_tgt[i]) == j);
               took[i]  = out_grant[i] && (int'(s1_tgt[i]) == j);
            end
         end

         vca_rr_arb #(.N(N)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_j),
            .gnt   (s2_gnt[j])
         );

         assign ovc_set[j] = |s2_gnt[j];

         assert_one_owner_per_cycle_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            $countones(took) <= 1);
      end
   endgenerate

   vca_busy #(.N(N)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ovc_set),
      .clr   (ovc_release),
      .busy  (ovc_busy)
   );
endmodule

// File: tb/sim_vca_alloc.sv
module sim_vca_alloc;
   localparam int BP  = 4;
   localparam int BV  = 2;
   localparam int BN  = BP * BV;
   localparam int BPW = 2;
   localparam int BVW = 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [BN-1:0]     valid = '0;
   logic [BN*BPW-1:0] portv = '0;
   logic [BN*BV-1:0]  mask = '0;
   logic [BN-1:0]     rel = '0;
   logic [BN-1:0]     out_grant;
   logic [BN*BVW-1:0] out_grant_vc;
   logic [BN-1:0]     ovc_busy;

   always #5 clk = ~clk;

   vca_alloc #(.P(BP), .V(BV)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (valid),
      .in_port      (portv),
      .in_vcmask    (mask),
      .ovc_release  (rel),
      .out_grant    (out_grant),
      .out_grant_vc (out_grant_vc),
      .ovc_busy     (ovc_busy)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   int mbusy [BN];
   int mptr  [BN];
   int mpick [BN];
   int mwin  [BN];
   logic [BN-1:0]     eg;
   logic [BN-1:0]     cap_gnt;
   logic [BN-1:0]     cap_busy;
   logic [BN*BVW-1:0] cap_vc;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic set_req(input int i, input int p, input int m);
      valid[i] = 1'b1;
      portv[i*BPW +: BPW] = BPW'(p);
      mask[i*BV +: BV] = BV'(m);
   endtask

   task automatic tick();
      logic [BN-1:0] mb;
      @(negedge clk);
      for (int i = 0; i < BN; i++) begin
         mpick[i] = -1;
         if (valid[i]) begin
            int p;
            p = int'(portv[i*BPW +: BPW]);
            for (int v = 0; v < BV; v++)
               if (mpick[i] < 0 && mask[i*BV + v] && mbusy[p*BV + v] == 0) mpick[i] = p*BV + v;
         end
      end
      eg = '0;
      for (int j = 0; j < BN; j++) begin
         mwin[j] = -1;
         for (int k = 0; k < BN; k++) begin
            int q;
            q = (mptr[j] + k) % BN;
            if (mwin[j] < 0 && mpick[q] == j) begin
               mwin[j] = q;
               eg[q] = 1'b1;
            end
         end
      end
      for (int j = 0; j < BN; j++) mb[j] = (mbusy[j] != 0);
      cap_gnt = out_grant;
      cap_busy = ovc_busy;
      cap_vc = out_grant_vc;
      check(out_grant == eg, "R5", "grant vector", int'(out_grant), int'(eg));
      check(ovc_busy == mb, "R6", "busy vector", int'(ovc_busy), int'(mb));
      for (int i = 0; i < BN; i++)
         if (eg[i])
            check(int'(out_grant_vc[i*BVW +: BVW]) == mpick[i] % BV, "R2", "granted channel",
                  int'(out_grant_vc[i*BVW +: BVW]), mpick[i] % BV);
      @(posedge clk);
      for (int j = 0; j < BN; j++) if (rel[j]) mbusy[j] = 0;
      for (int j = 0; j < BN; j++)
         if (mwin[j] >= 0) begin
            mbusy[j] = 1;
            mptr[j] = (mwin[j] + 1) % BN;
         end
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R8 watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   int st  [BN];
   int own [BN];
   int hc  [BN];

   initial begin
      for (int j = 0; j < BN; j++) begin
         mbusy[j] = 0;
         mptr[j] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      tick();
      check(cap_gnt == '0, "R1", "no grant after reset", int'(cap_gnt), 0);
      check(cap_busy == '0, "R1", "all free after reset", int'(cap_busy), 0);

      // R3 R5: inputs 0 and 3 both pick port 1 channel 0, pointer at 0
      set_req(0, 1, 3);
      set_req(3, 1, 3);
      tick();
      check(cap_gnt == 8'b0000_0001, "R3", "one winner of contention", int'(cap_gnt), 1);
      check(cap_vc[0] == 1'b0, "R5", "lowest free channel", int'(cap_vc[0]), 0);
      valid[0] = 1'b0;
      // R8 loser retries and finds channel 1 now free
      tick();
      check(cap_gnt == 8'b0000_1000, "R8", "loser granted on retry", int'(cap_gnt), 8);
      check(cap_vc[3] == 1'b1, "R8", "retry gets next channel", int'(cap_vc[3]), 1);
      check(cap_busy == 8'b0000_0100, "R6", "busy after grant", int'(cap_busy), 4);
      valid[3] = 1'b0;

      // R4 no free channel at port 1
      set_req(5, 1, 3);
      tick();
      check(cap_gnt == '0, "R4", "no grant when all busy", int'(cap_gnt), 0);
      check(cap_busy == 8'b0000_1100, "R6", "both held", int'(cap_busy), 12);

      // R6 release pulse: not grantable in the same cycle
      rel = 8'b0000_0100;
      tick();
      check(cap_gnt == '0, "R6", "no grant in release cycle", int'(cap_gnt), 0);
      rel = '0;
      tick();
      check(cap_gnt == 8'b0010_0000, "R6", "grant cycle after release", int'(cap_gnt), 32);
      valid[5] = 1'b0;

      // R2 mask excludes channel 0
      set_req(6, 2, 2);
      tick();
      check(cap_gnt == 8'b0100_0000, "R2", "masked request granted", int'(cap_gnt), 64);
      check(cap_vc[6] == 1'b1, "R2", "mask forces channel 1", int'(cap_vc[6]), 1);
      valid[6] = 1'b0;

      // R5 pointer of channel 2 now past input 5
      rel = 8'b0000_0100;
      tick();
      rel = '0;
      set_req(0, 1, 1);
      set_req(7, 1, 1);
      tick();
      check(cap_gnt == 8'b1000_0000, "R5", "rotated priority winner", int'(cap_gnt), 128);
      valid[7] = 1'b0;
      rel = 8'b0000_0100;
      tick();
      rel = '0;
      tick();
      check(cap_gnt == 8'b0000_0001, "R5", "wrapped pointer winner", int'(cap_gnt), 1);
      valid[0] = 1'b0;

      // R7 release on free channels
      rel = 8'b0000_0011;
      tick();
      rel = '0;
      tick();
      check(cap_busy == 8'b0010_1100, "R7", "free release no effect", int'(cap_busy), 8'h2c);

      rel = 8'b0010_1100;
      tick();
      rel = '0;
      tick();

      // random traffic against the model
      for (int i = 0; i < BN; i++) st[i] = 0;
      for (int c = 0; c < 3000; c++) begin
         rel = '0;
         for (int i = 0; i < BN; i++) begin
            if (st[i] == 2) begin
               hc[i]--;
               if (hc[i] <= 0) begin
                  rel[own[i]] = 1'b1;
                  st[i] = 0;
               end
            end else if (st[i] == 0 && ($urandom % 3) == 0) begin
               set_req(i, int'($urandom % BP), int'($urandom % 3) + 1);
               st[i] = 1;
            end
         end
         if (($urandom % 5) == 0) begin
            int j;
            j = int'($urandom % BN);
            if (mbusy[j] == 0) rel[j] = 1'b1;
         end
         tick();
         for (int i = 0; i < BN; i++)
            if (st[i] == 1 && eg[i]) begin
               st[i] = 2;
               own[i] = mpick[i];
               hc[i] = int'($urandom % 6) + 1;
               valid[i] = 1'b0;
            end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule